// File: doc/BRIEF.md
# Prescaled Down-Counter Timer

This block is a small timer for a CPU subsystem. A 7-bit prescaler counts down on every enabled clock. Its taps feed an 8-bit down-counter at a chosen power-of-two rate. Software talks to the timer through three byte-wide registers on a synchronous write / combinational read bus:

- the prescaler value;
- the counter value;
- a control byte.

The control byte holds a zero flag, an interrupt enable, an output-mode select, a data-out bit, a run bit and a 3-bit rate select.

When the counter steps down to zero, the zero flag rises. The flag can also be raised by software, and only software lowers it. The interrupt request is the AND of the flag and the enable bit.

In output mode, the timer pin is driven through a latch built from a register and a multiplexer. While the flag is high the pin follows data-out, and it keeps its last value once the flag drops. In input mode with data-out set, the synchronized pin gates the count.

Counting is governed by a three-state run controller:

- `ST_HALT`: stopped. The prescaler is forced to 0x7F and the counter is frozen.
- `ST_COUNT`: the prescaler decrements on every clock.
- `ST_GATED`: paused by a low gate pin. Both prescaler and counter hold.

The transitions are:

- START: `ST_HALT` to `ST_COUNT`.
- START_GATED: `ST_HALT` to `ST_GATED`.
- PAUSE: `ST_COUNT` to `ST_GATED`.
- RESUME: `ST_GATED` to `ST_COUNT`.
- STOP: any state to `ST_HALT`.

The next state is chosen from the registered run bit, the gate condition and the synchronized pin.

Top module: `ptimer_top`

## Requirements
- R1: After reset the prescaler reads 0x7F, the counter reads 0xFF, the control byte reads 0x00, and irq, pin_oe and pin_out are 0.
- R2: Registers are at bus_addr 0 (prescaler), 1 (counter) and 2 (control); address 3 reads 0x00. Writes happen on a clock edge with bus_sel and bus_wr both high. bus_rdata always shows the live value of the addressed register, and bit 7 of the prescaler reads 0. Control bit layout: 7 zero flag, 6 interrupt enable, 5 output mode, 4 data-out, 3 run, 2..0 rate select.
- R3: With the run bit 0 the controller is in ST_HALT. In that state the prescaler is forced to 0x7F, overriding prescaler writes, and the counter does not decrement. After a write sets the run bit, the first prescaler and counter decrement happens on the second following edge.
- R4: In ST_COUNT the prescaler decrements each cycle. The counter decrements in a cycle where the low k bits of the prescaler are all 0, where k is the rate select (k = 0 gives every cycle). This yields a division of 2^k.
- R5: A counter decrement from 0x01 to 0x00 sets the zero flag at that same edge.
- R6: Writing 0x00 to the counter sets the zero flag. A control write sets the flag when bit 7 is 1 and clears it when bit 7 is 0. A hardware set in the same cycle as a clearing control write leaves the flag at 1.
- R7: A counter write in the same cycle as a decrement to 0x00 wins: the counter takes the written value, and the flag is not set unless the written value is 0x00.
- R8: irq is 1 exactly when both the interrupt-enable bit and the zero flag are 1.
- R9: pin_oe equals the output-mode bit. While the zero flag is 1, pin_out equals data-out. While the flag is 0, pin_out holds the data-out value present in the last cycle the flag was 1.
- R10: The counter wraps from 0x00 to 0xFF on its next decrement, and the prescaler wraps from 0x00 to 0x7F.
- R11: When the output-mode bit is 0 and data-out is 1, pin_in passes through a two-flop synchronizer, and a synchronized low puts the controller in ST_GATED, where nothing counts. When data-out is 0, pin_in has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pin_in | input | 1 | Timer pin input (count gate) |
| pin_out | output | 1 | Timer pin output value |
| pin_oe | output | 1 | Timer pin output enable |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can fall in one edge: a counter write against the hardware decrement to zero, and a hardware flag set against a control write that clears the flag. Directed cases use the bench's own model to wait until the counter reads 0x01 with the fastest rate running. They then issue the write on exactly that edge and confirm the written counter value and the resulting flag state at the ports. A long seeded random phase adds unplanned collisions of both kinds, and every cycle is compared against the model for read data, irq and both pin outputs.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;

    localparam int BUS_W = 8;

    localparam logic [1:0] OFS_PSC = 2'd0;
    localparam logic [1:0] OFS_CNT = 2'd1;
    localparam logic [1:0] OFS_CTL = 2'd2;

    localparam int BIT_ZF    = 7;
    localparam int BIT_IE    = 6;
    localparam int BIT_OMODE = 5;
    localparam int BIT_DOUT  = 4;
    localparam int BIT_RUN   = 3;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_COUNT = 2'd1,
        ST_GATED = 2'd2
    } run_state_t;

endpackage

// File: rtl/ptimer_ctl.sv
module ptimer_ctl
    import ptimer_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       gate_en,
    input  logic       pin_in,
    output run_state_t state_o,
    output logic       count_en,
    output logic       halt
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_sync;
    run_state_t             state_q;
    run_state_t             state_d;
    logic                   pause_req;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin_in;
            end
        end else begin : g_syncn
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
            end
        end
    endgenerate

    assign pin_sync  = sync_q[SYNC_STAGES-1];
    assign pause_req = gate_en && !pin_sync;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: begin
                if (run && pause_req) state_d = ST_GATED;   // START_GATED
                else if (run)         state_d = ST_COUNT;   // START
            end
            ST_COUNT: begin
                if (!run)           state_d = ST_HALT;      // STOP
                else if (pause_req) state_d = ST_GATED;     // PAUSE
            end
            ST_GATED: begin
                if (!run)            state_d = ST_HALT;     // STOP
                else if (!pause_req) state_d = ST_COUNT;    // RESUME
            end
            default: state_d = ST_HALT;
        endcase
    end

    always_comb begin
        state_o  = state_q;
        count_en = 1'b0;
        halt     = 1'b0;
        unique case (state_q)
            ST_HALT:  halt     = 1'b1;
            ST_COUNT: count_en = 1'b1;
            ST_GATED: ;
            default:  halt     = 1'b1;
        endcase
    end

    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> state_q == ST_HALT); // R3

    AST_GATE_PAUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (run && gate_en && !pin_sync) |=> !count_en); // R11

endmodule

// File: rtl/ptimer_presc.sv
module ptimer_presc #(
    parameter int PSC_W = 7,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt,
    input  logic             count_en,
    input  logic             wr,
    input  logic [PSC_W-1:0] wdata,
    input  logic [SEL_W-1:0] div_sel,
    output logic [PSC_W-1:0] value,
    output logic             tick
);

    logic [PSC_W-1:0] psc_q;
    logic [PSC_W:0]   tap_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        psc_q <= '1;
        else if (halt)     psc_q <= '1;
        else if (wr)       psc_q <= wdata;
        else if (count_en) psc_q <= psc_q - 1'b1;
    end

    assign tap_ok[0] = 1'b1;

    generate
        for (genvar k = 1; k <= PSC_W; k++) begin : g_tap
            assign tap_ok[k] = (psc_q[k-1:0] == '0);
        end
    endgenerate

    assign tick  = count_en && tap_ok[div_sel];
    assign value = psc_q;

    AST_PSC_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> psc_q == '1); // R3

    AST_PSC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && !wr && count_en && psc_q == '0) |=> psc_q == '1); // R10

endmodule

// File: rtl/ptimer_cnt.sv
module ptimer_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] value,
    output logic             zero_hit
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '1;
        else if (wr)   cnt_q <= wdata;
        else if (tick) cnt_q <= cnt_q - 1'b1;
    end

    always_comb begin
        if (wr) zero_hit = (wdata == '0);
        else    zero_hit = tick && (cnt_q == ONE);
    end

    assign value = cnt_q;

    AST_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> cnt_q == $past(wdata)); // R7

    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !tick) |=> $stable(cnt_q)); // R3

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && tick && cnt_q == '0) |=> cnt_q == '1); // R10

endmodule

// File: rtl/ptimer_top.sv
module ptimer_top
    import ptimer_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PSC_W       = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             pin_in,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             irq
);

    localparam int SEL_W = $clog2(PSC_W + 1);

    logic             wr_any, psc_wr, cnt_wr, ctl_wr;
    logic             zf_q, ie_q, omode_q, dout_q, run_q, held_q;
    logic [SEL_W-1:0] div_q;
    logic [PSC_W-1:0] psc_val;
    logic [CNT_W-1:0] cnt_val;
    logic             tick, zero_hit, count_en, halt, gate_en;
    run_state_t       run_state;

    assign wr_any = bus_sel && bus_wr;
    assign psc_wr = wr_any && (bus_addr == OFS_PSC);
    assign cnt_wr = wr_any && (bus_addr == OFS_CNT);
    assign ctl_wr = wr_any && (bus_addr == OFS_CTL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q    <= 1'b0;
            omode_q <= 1'b0;
            dout_q  <= 1'b0;
            run_q   <= 1'b0;
            div_q   <= '0;
        end else if (ctl_wr) begin
            ie_q    <= bus_wdata[BIT_IE];
            omode_q <= bus_wdata[BIT_OMODE];
            dout_q  <= bus_wdata[BIT_DOUT];
            run_q   <= bus_wdata[BIT_RUN];
            div_q   <= bus_wdata[SEL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        zf_q <= 1'b0;
        else if (zero_hit) zf_q <= 1'b1;
        else if (ctl_wr)   zf_q <= bus_wdata[BIT_ZF];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    held_q <= 1'b0;
        else if (zf_q) held_q <= dout_q;
    end

    assign gate_en = !omode_q && dout_q;

    ptimer_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_q),
        .gate_en  (gate_en),
        .pin_in   (pin_in),
        .state_o  (run_state),
        .count_en (count_en),
        .halt     (halt)
    );

    ptimer_presc #(.PSC_W(PSC_W), .SEL_W(SEL_W)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt     (halt),
        .count_en (count_en),
        .wr       (psc_wr),
        .wdata    (bus_wdata[PSC_W-1:0]),
        .div_sel  (div_q),
        .value    (psc_val),
        .tick     (tick)
    );

    ptimer_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .wr       (cnt_wr),
        .wdata    (bus_wdata[CNT_W-1:0]),
        .value    (cnt_val),
        .zero_hit (zero_hit)
    );

    always_comb begin
        unique case (bus_addr)
            OFS_PSC: bus_rdata = BUS_W'(psc_val);
            OFS_CNT: bus_rdata = BUS_W'(cnt_val);
            OFS_CTL: bus_rdata = BUS_W'({zf_q, ie_q, omode_q, dout_q, run_q, div_q});
            default: bus_rdata = '0;
        endcase
    end

    assign pin_out = zf_q ? dout_q : held_q;
    assign pin_oe  = omode_q;
    assign irq     = ie_q && zf_q;

    AST_ZF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        zero_hit |=> zf_q); // R5

    AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !zf_q |=> (zf_q || $stable(pin_out))); // R9

    AST_PSC_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_PSC) |-> !bus_rdata[BUS_W-1]); // R2

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> bus_rdata[BIT_ZF] || bus_addr != OFS_CTL); // R8

endmodule

// File: tb/ptimer_top_test.sv
module ptimer_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYC    = 200000;
    localparam int SEED       = 1234;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       pin_in = 1'b0;
    logic       pin_out, pin_oe, irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptimer_top uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // reference model of the requirements
    logic [7:0] m_cnt = 8'hFF;
    logic [6:0] m_psc = 7'h7F;
    logic [7:0] m_ctl = 8'h00;
    logic       m_held = 1'b0, m_s1 = 1'b0, m_s2 = 1'b0;
    int         m_state = 0;   // 0 halt, 1 count, 2 gated

    function automatic logic tap_ok(input logic [6:0] p, input logic [2:0] k);
        if (k == 3'd0) return 1'b1;
        return (p & 7'((1 << k) - 1)) == 7'd0;
    endfunction

    function automatic logic [7:0] model_read(input logic [1:0] a);
        case (a)
            2'd0:    return {1'b0, m_psc};
            2'd1:    return m_cnt;
            2'd2:    return m_ctl;
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic wr_psc, wr_cnt, wr_ctl, tick, gate, hw;
        int   ns;
        if (!rst_n) begin
            m_cnt = 8'hFF; m_psc = 7'h7F; m_ctl = 8'h00;
            m_held = 1'b0; m_s1 = 1'b0; m_s2 = 1'b0; m_state = 0;
        end else begin
            wr_psc = bus_sel && bus_wr && bus_addr == 2'd0;
            wr_cnt = bus_sel && bus_wr && bus_addr == 2'd1;
            wr_ctl = bus_sel && bus_wr && bus_addr == 2'd2;
            gate   = !m_ctl[5] && m_ctl[4];
            if (!m_ctl[3])          ns = 0;
            else if (gate && !m_s2) ns = 2;
            else                    ns = 1;
            tick = (m_state == 1) && tap_ok(m_psc, m_ctl[2:0]);
            hw   = wr_cnt ? (bus_wdata == 8'h00) : (tick && m_cnt == 8'h01);
            if (m_ctl[7]) m_held = m_ctl[4];
            if (m_state == 0)      m_psc = 7'h7F;
            else if (wr_psc)       m_psc = bus_wdata[6:0];
            else if (m_state == 1) m_psc = m_psc - 7'd1;
            if (wr_cnt)    m_cnt = bus_wdata;
            else if (tick) m_cnt = m_cnt - 8'd1;
            if (wr_ctl) m_ctl[6:0] = bus_wdata[6:0];
            if (hw)          m_ctl[7] = 1'b1;
            else if (wr_ctl) m_ctl[7] = bus_wdata[7];
            m_s2 = m_s1;
            m_s1 = pin_in;
            m_state = ns;
        end
    end

    task automatic check(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, "rdata",   bus_rdata, model_read(bus_addr));
        check(tag, "irq",     {7'd0, irq},    {7'd0, m_ctl[6] & m_ctl[7]});
        check(tag, "pin_oe",  {7'd0, pin_oe}, {7'd0, m_ctl[5]});
        check(tag, "pin_out", {7'd0, pin_out}, {7'd0, (m_ctl[7] ? m_ctl[4] : m_held)});
    endtask

    task automatic step(input string tag, input logic wr, input logic [1:0] a,
                        input logic [7:0] d, input logic pin);
        bus_sel = wr; bus_wr = wr; bus_addr = a; bus_wdata = d; pin_in = pin;
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic idle(input string tag, input logic [1:0] a, input int n);
        for (int i = 0; i < n; i++) step(tag, 1'b0, a, 8'h00, pin_in);
    endtask

    task automatic wait_pre_zero(input string tag);
        int guard = 0;
        while (!(m_state == 1 && m_cnt == 8'h01) && guard < 1000) begin
            step(tag, 1'b0, 2'd1, 8'h00, pin_in);
            guard++;
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    endtask

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1: actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        void'($urandom(SEED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        step("R1", 0, 2'd0, 8'h00, 0); check("R1", "psc", bus_rdata, 8'h7F);
        check("R1", "irq", {7'd0, irq}, 8'h00);
        check("R1", "pin_oe", {7'd0, pin_oe}, 8'h00);
        check("R1", "pin_out", {7'd0, pin_out}, 8'h00);
        step("R1", 0, 2'd1, 8'h00, 0); check("R1", "cnt", bus_rdata, 8'hFF);
        step("R1", 0, 2'd2, 8'h00, 0); check("R1", "ctl", bus_rdata, 8'h00);
        step("R2", 0, 2'd3, 8'h00, 0); check("R2", "addr3", bus_rdata, 8'h00);

        // R3 halted prescaler ignores writes; start latency
        step("R3", 1, 2'd0, 8'h10, 0); check("R3", "psc held", bus_rdata, 8'h7F);
        step("R3", 1, 2'd2, 8'h08, 0); check("R3", "ctl", bus_rdata, 8'h08);
        step("R3", 0, 2'd1, 8'h00, 0); check("R3", "cnt before start", bus_rdata, 8'hFF);
        step("R3", 0, 2'd1, 8'h00, 0); check("R3", "first decrement", bus_rdata, 8'hFE);
        idle("R3", 2'd0, 5);

        // R4 every rate select
        for (int k = 0; k < 8; k++) begin
            step("R4", 1, 2'd2, 8'h08 | 8'(k), 0);
            step("R4", 1, 2'd1, 8'h40, 0);
            for (int i = 0; i < 300; i++) step("R4", 0, 2'(i % 2), 8'h00, 0);
        end

        // R5 decrement to zero sets flag, R10 wrap
        step("R5", 1, 2'd2, 8'h08, 0);
        step("R5", 1, 2'd1, 8'h03, 0);
        idle("R5", 2'd1, 3);
        check("R5", "cnt at zero", bus_rdata, 8'h00);
        step("R5", 0, 2'd2, 8'h00, 0);
        check("R5", "flag", {7'd0, bus_rdata[7]}, 8'h01);
        step("R10", 0, 2'd1, 8'h00, 0);
        check("R10", "cnt wrap", bus_rdata, 8'hFE);
        idle("R10", 2'd0, 140);

        // R6 software set/clear
        step("R6", 1, 2'd2, 8'h00, 0); check("R6", "clear", bus_rdata, 8'h00);
        step("R6", 1, 2'd2, 8'h80, 0); check("R6", "set by bit7", bus_rdata, 8'h80);
        step("R6", 1, 2'd2, 8'h00, 0);
        step("R6", 1, 2'd1, 8'h00, 0);
        step("R6", 0, 2'd2, 8'h00, 0); check("R6", "set by cnt=0", bus_rdata, 8'h80);
        // hardware set vs clearing write
        step("R6", 1, 2'd2, 8'h08, 0);
        step("R6", 1, 2'd1, 8'h04, 0);
        wait_pre_zero("R6");
        step("R6", 1, 2'd2, 8'h08, 0);
        check("R6", "hw set beats clear", {7'd0, bus_rdata[7]}, 8'h01);

        // R7 write beats decrement to zero
        step("R7", 1, 2'd2, 8'h08, 0);
        step("R7", 1, 2'd1, 8'h05, 0);
        wait_pre_zero("R7");
        step("R7", 1, 2'd1, 8'h05, 0);
        check("R7", "written value", bus_rdata, 8'h05);
        step("R7", 0, 2'd2, 8'h00, 0);
        check("R7", "no flag", {7'd0, bus_rdata[7]}, 8'h00);

        // R8 interrupt
        step("R8", 1, 2'd2, 8'h48, 0); check("R8", "irq off", {7'd0, irq}, 8'h00);
        step("R8", 1, 2'd2, 8'hC8, 0); check("R8", "irq on", {7'd0, irq}, 8'h01);
        step("R8", 1, 2'd2, 8'h48, 0); check("R8", "irq cleared", {7'd0, irq}, 8'h00);

        // R9 output latch
        step("R9", 1, 2'd2, 8'hB0, 0);
        check("R9", "oe", {7'd0, pin_oe}, 8'h01);
        check("R9", "transparent 1", {7'd0, pin_out}, 8'h01);
        step("R9", 1, 2'd2, 8'hA0, 0); check("R9", "transparent 0", {7'd0, pin_out}, 8'h00);
        step("R9", 1, 2'd2, 8'hB0, 0); check("R9", "transparent 1b", {7'd0, pin_out}, 8'h01);
        step("R9", 1, 2'd2, 8'h30, 0); check("R9", "hold after fall", {7'd0, pin_out}, 8'h01);
        step("R9", 1, 2'd2, 8'h20, 0); check("R9", "hold vs dout", {7'd0, pin_out}, 8'h01);
        step("R9", 1, 2'd2, 8'h00, 0);

        // R11 gating
        step("R11", 1, 2'd2, 8'h18, 0);
        step("R11", 1, 2'd1, 8'h80, 0);
        idle("R11", 2'd1, 5);
        check("R11", "gated frozen", bus_rdata, 8'h80);
        step("R11", 0, 2'd1, 8'h00, 1);
        idle("R11", 2'd1, 3);
        check("R11", "resumed", bus_rdata, 8'h7F);
        step("R11", 1, 2'd2, 8'h08, 0);
        for (int i = 0; i < 40; i++) step("R11", 0, 2'd1, 8'h00, 1'(i % 3 == 0));
        rd = bus_rdata;
        step("R11", 0, 2'd1, 8'h00, 0);
        check("R11", "pin ignored", bus_rdata, rd - 8'd1);

        // random phase
        for (int i = 0; i < 6000; i++) begin
            logic       w;
            logic [7:0] d;
            logic       p;
            w = ($urandom % 8) == 0;
            d = 8'($urandom);
            p = (($urandom % 4) == 0) ? ~pin_in : pin_in;
            if (w && ($urandom % 2) == 0) d[3] = 1'b1;
            step("R2", w, 2'($urandom), d, p);
        end

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule